// File: doc/BRIEF.md
# Recovered-Clock Lock Supervisor

This block decides whether a clock-recovery loop should follow the incoming line data or fall back to the local reference clock. It counts recovered-clock edges over fixed windows of reference cycles and compares each count against a tolerance band around the nominal count. Two matching window verdicts in a row are needed before it changes state, so one noisy window cannot make it chatter. Out of reset the loop is held on the reference. Tracking of the line data, with lock-detect raised, begins only after two good windows have passed while loss of signal is clear.

The flag for missing optical power from the optics module is combined with a polarity-select pin by an XNOR, so modules that drive the flag either way round can be used. The result is synchronised and reported as a loss-of-signal output. While loss of signal is present, lock is forced low and the receive data word can optionally be muted to zeros. The downstream receive clock is taken from the reference whenever the loop is not tracking data, so it keeps running. A one-cycle status-change pulse marks every edge of lock-detect or loss-of-signal detect.

Top module: `cdr_lock_monitor`

## Requirements
- R1: While reset is asserted and after its release, srcSel and lockDet are 0, which means the loop uses the reference.
- R2: At the end of every window of 2^WIN_LOG2 reference cycles, the number of recovered-clock edges in that window is rated good if it lies within 2^WIN_LOG2 ± (2^WIN_LOG2·PPM_LIMIT/10^6). With the defaults this is 8192 ± 4. A 2000 ppm slow recovered clock is rated bad and a 200 ppm slow one is rated good.
- R3: lockDet and srcSel rise at the end of the second consecutive good window, counted while loss of signal is clear. They fall at the end of the second consecutive bad window. A single window of the opposite verdict changes nothing.
- R4: A high losDet forces lockDet and srcSel low on the following reference edge, whatever the window verdicts are. It also restarts the good-window count.
- R5: losDet equals the XNOR of the raw flag, after two synchroniser flops, with losPolarity. A change of the raw flag shows on losDet after the second reference edge. A change of losPolarity shows at once.
- R6: When muteEn is 1 and losDet is 1, rxDataOut is 0. Otherwise rxDataOut equals rxDataIn.
- R7: rxClkOut follows refClk while srcSel is 0 and follows recClk while srcSel is 1.
- R8: statusChg is high for exactly one reference cycle after each change of lockDet and after each change of losDet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Local reference clock; all control logic runs on it |
| recClk | input | 1 | Recovered clock from the loop |
| rstN | input | 1 | Asynchronous active-low reset |
| losRaw | input | 1 | Raw optical-power flag from the optics module |
| losPolarity | input | 1 | Polarity select for losRaw (XNOR) |
| muteEn | input | 1 | Enables zeroing of receive data during loss of signal |
| rxDataIn | input | DATA_W | Parallel receive data word |
| rxDataOut | output | DATA_W | Receive data word, muted when enabled |
| lockDet | output | 1 | Lock detected, loop tracking data |
| losDet | output | 1 | Loss of signal detected |
| srcSel | output | 1 | Loop source: 0 reference, 1 data |
| statusChg | output | 1 | One-cycle pulse on any lockDet or losDet change |
| rxClkOut | output | 1 | Downstream receive clock |

## Verification
Loss of signal and the window verdict can act on the controller in the same reference cycle. When they do, loss of signal must win and the good verdict must not count. The bench provokes this by holding the flag active across two window ends during which the recovered frequency is in tolerance. It judges the result by lockDet staying low through both window ends and rising exactly two window ends after the flag clears. Muting and the loss-of-signal report also change together, so rxDataOut is checked in the same cycles in which losDet is checked.

// File: rtl/cdr_mon_pkg.sv
package cdr_mon_pkg;

  // verdicts passed from the datapath to the control
  typedef struct packed {
    logic winDone;   // measurement window ends this cycle
    logic winGood;   // count of that window is inside the band
    logic los;       // synchronised, polarity-corrected loss of signal
  } meas_t;

  typedef enum logic {
    SRC_REF  = 1'b0,
    SRC_DATA = 1'b1
  } src_e;

endpackage

// File: rtl/cdr_mon_datapath.sv
module cdr_mon_datapath
  import cdr_mon_pkg::*;
#(
  parameter int WIN_LOG2  = 13,
  parameter int PPM_LIMIT = 500,
  parameter int DATA_W    = 4
) (
  input  logic              refClk,
  input  logic              recClk,
  input  logic              rstN,
  input  logic              losRaw,
  input  logic              losPolarity,
  input  logic              muteEn,
  input  logic [DATA_W-1:0] rxDataIn,
  output logic [DATA_W-1:0] rxDataOut,
  output logic              losDet,
  output meas_t             meas
);

  localparam int CW      = WIN_LOG2 + 2;
  localparam int EXP_CNT = 2 ** WIN_LOG2;
  localparam int TOL     = (EXP_CNT * PPM_LIMIT) / 1000000;
  localparam logic [CW-1:0] LO_LIM = CW'(EXP_CNT - TOL);
  localparam logic [CW-1:0] HI_LIM = CW'(EXP_CNT + TOL);

  // recovered-clock domain: binary and Gray edge counters
  logic [CW-1:0] recBin, recBinNext, recGray;
  assign recBinNext = recBin + 1'b1;

  always_ff @(posedge recClk or negedge rstN) begin
    if (!rstN) begin
      recBin  <= '0;
      recGray <= '0;
    end else begin
      recBin  <= recBinNext;
      recGray <= recBinNext ^ (recBinNext >> 1);
    end
  end

  // reference domain: Gray synchroniser and conversion back to binary
  logic [CW-1:0] graySync1, graySync2, syncBin;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      graySync1 <= '0;
      graySync2 <= '0;
    end else begin
      graySync1 <= recGray;
      graySync2 <= graySync1;
    end
  end

  for (genvar i = 0; i < CW; i++) begin : g_gray2bin
    assign syncBin[i] = ^(graySync2 >> i);
  end

  // measurement window
  logic [WIN_LOG2-1:0] refCnt;
  logic [CW-1:0]       snapQ, delta;
  logic                winEnd;

  assign winEnd = &refCnt;
  assign delta  = syncBin - snapQ;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      refCnt <= '0;
      snapQ  <= '0;
    end else begin
      refCnt <= refCnt + 1'b1;
      if (winEnd) snapQ <= syncBin;
    end
  end

  // loss of signal: two-flop synchroniser, then polarity XNOR
  logic losSync1, losSync2;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      losSync1 <= 1'b0;
      losSync2 <= 1'b0;
    end else begin
      losSync1 <= losRaw;
      losSync2 <= losSync1;
    end
  end

  assign losDet       = ~(losSync2 ^ losPolarity);
  assign meas.winDone = winEnd;
  assign meas.winGood = (delta >= LO_LIM) && (delta <= HI_LIM);
  assign meas.los     = losDet;

  assign rxDataOut = (muteEn && losDet) ? '0 : rxDataIn;

  // R2: windows are separated by a full count, never back to back
  a_r2_window_spacing: assert property (@(posedge refClk) disable iff (!rstN)
    meas.winDone |=> !meas.winDone);

  // R5: a rise of losDet under fixed polarity follows the raw flag two edges earlier
  a_r5_los_latency: assert property (@(posedge refClk) disable iff (!rstN)
    ($rose(losDet) && $stable(losPolarity)) |-> $past(losRaw == losPolarity, 2));

endmodule

// File: rtl/cdr_mon_control.sv
module cdr_mon_control
  import cdr_mon_pkg::*;
#(
  parameter int HYST_WIN = 2
) (
  input  logic  refClk,
  input  logic  rstN,
  input  meas_t meas,
  output logic  lockDet,
  output logic  srcSel,
  output logic  statusChg
);

  localparam int HW = $clog2(HYST_WIN + 1);
  localparam logic [HW-1:0] LAST = HW'(HYST_WIN - 1);

  src_e          stateQ;
  logic [HW-1:0] goodCnt, badCnt;
  logic          lockPrevQ, losPrevQ;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= SRC_REF;
      goodCnt   <= '0;
      badCnt    <= '0;
      lockPrevQ <= 1'b0;
      losPrevQ  <= 1'b0;
    end else begin
      lockPrevQ <= lockDet;
      losPrevQ  <= meas.los;
      if (meas.los) begin
        stateQ  <= SRC_REF;
        goodCnt <= '0;
        badCnt  <= '0;
      end else if (meas.winDone) begin
        if (stateQ == SRC_REF) begin
          badCnt <= '0;
          if (!meas.winGood)       goodCnt <= '0;
          else if (goodCnt == LAST) begin
            stateQ  <= SRC_DATA;
            goodCnt <= '0;
          end else                 goodCnt <= goodCnt + 1'b1;
        end else begin
          goodCnt <= '0;
          if (meas.winGood)        badCnt <= '0;
          else if (badCnt == LAST) begin
            stateQ <= SRC_REF;
            badCnt <= '0;
          end else                 badCnt <= badCnt + 1'b1;
        end
      end
    end
  end

  assign lockDet   = (stateQ == SRC_DATA);
  assign srcSel    = (stateQ == SRC_DATA);
  assign statusChg = (lockDet ^ lockPrevQ) | (meas.los ^ losPrevQ);

  // R1: reset holds the loop on the reference
  a_r1_reset_ref: assert property (@(posedge refClk)
    !rstN |=> !lockDet);

  // R4: loss of signal drops lock on the next edge
  a_r4_los_drops_lock: assert property (@(posedge refClk) disable iff (!rstN)
    meas.los |=> !lockDet);

  // R3: lock is gained only on a good window end without loss of signal
  a_r3_lock_on_good: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(lockDet) |-> $past(meas.winDone && meas.winGood && !meas.los));

  // R3: lock is lost only on a bad window end or on loss of signal
  a_r3_drop_cause: assert property (@(posedge refClk) disable iff (!rstN)
    $fell(lockDet) |-> $past(meas.los || (meas.winDone && !meas.winGood)));

endmodule

// File: rtl/cdr_lock_monitor.sv
module cdr_lock_monitor
  import cdr_mon_pkg::*;
#(
  parameter int WIN_LOG2  = 13,
  parameter int PPM_LIMIT = 500,
  parameter int HYST_WIN  = 2,
  parameter int DATA_W    = 4
) (
  input  logic              refClk,
  input  logic              recClk,
  input  logic              rstN,
  input  logic              losRaw,
  input  logic              losPolarity,
  input  logic              muteEn,
  input  logic [DATA_W-1:0] rxDataIn,
  output logic [DATA_W-1:0] rxDataOut,
  output logic              lockDet,
  output logic              losDet,
  output logic              srcSel,
  output logic              statusChg,
  output logic              rxClkOut
);

  meas_t meas;

  cdr_mon_datapath #(
    .WIN_LOG2 (WIN_LOG2),
    .PPM_LIMIT(PPM_LIMIT),
    .DATA_W   (DATA_W)
  ) datapath_i (
    .refClk     (refClk),
    .recClk     (recClk),
    .rstN       (rstN),
    .losRaw     (losRaw),
    .losPolarity(losPolarity),
    .muteEn     (muteEn),
    .rxDataIn   (rxDataIn),
    .rxDataOut  (rxDataOut),
    .losDet     (losDet),
    .meas       (meas)
  );

  cdr_mon_control #(
    .HYST_WIN(HYST_WIN)
  ) control_i (
    .refClk   (refClk),
    .rstN     (rstN),
    .meas     (meas),
    .lockDet  (lockDet),
    .srcSel   (srcSel),
    .statusChg(statusChg)
  );

  // downstream clock keeps running from the reference when not tracking
  assign rxClkOut = srcSel ? recClk : refClk;

endmodule

// File: tb/cdr_lock_monitor_tb_top.sv
`timescale 1ns/1ps
module cdr_lock_monitor_tb_top;

  localparam real REF_PERIOD = 10.0;
  localparam int  WIN        = 8192;

  logic       refClk = 1'b0;
  logic       recClk = 1'b0;
  logic       rstN = 1'b0;
  logic       losRaw = 1'b0;
  logic       losPolarity = 1'b1;
  logic       muteEn = 1'b1;
  logic [3:0] rxDataIn = 4'hA;
  logic [3:0] rxDataOut;
  logic       lockDet, losDet, srcSel, statusChg, rxClkOut;

  real recHalf = REF_PERIOD / 2.0;
  int  refEdges = 0;
  int  tests = 0;
  int  fails = 0;

  cdr_lock_monitor dut_i (
    .refClk(refClk), .recClk(recClk), .rstN(rstN), .losRaw(losRaw),
    .losPolarity(losPolarity), .muteEn(muteEn), .rxDataIn(rxDataIn),
    .rxDataOut(rxDataOut), .lockDet(lockDet), .losDet(losDet),
    .srcSel(srcSel), .statusChg(statusChg), .rxClkOut(rxClkOut)
  );

  always #(REF_PERIOD / 2.0) refClk = ~refClk;

  initial begin
    #(REF_PERIOD / 4.0);
    forever #(recHalf) recClk = ~recClk;
  end

  always @(posedge refClk) if (rstN) refEdges <= refEdges + 1;

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitEdge(input int n);
    while (refEdges < n) @(negedge refClk);
  endtask

  task automatic stepEdge();
    @(negedge refClk);
  endtask

  task automatic t_reset();
    check("R1 lockDet in reset", int'(lockDet), 0);
    check("R1 srcSel in reset", int'(srcSel), 0);
    check("R5 losDet in reset", int'(losDet), 0);
    check("R6 data passes without LOS", int'(rxDataOut), 10);
    rstN = 1'b1;
    stepEdge();
    check("R1 srcSel after reset", int'(srcSel), 0);
    check("R8 no status pulse after reset", int'(statusChg), 0);
  endtask

  task automatic t_acquire();
    waitEdge(WIN + 10);
    check("R3 one good window keeps reference", int'(lockDet), 0);
    check("R7 rxClkOut low with refClk", int'(rxClkOut), int'(refClk));
    #(REF_PERIOD * 0.6);
    check("R7 rxClkOut high with refClk", int'(rxClkOut), int'(refClk));
    waitEdge(2 * WIN);
    check("R3 lock after two good windows", int'(lockDet), 1);
    check("R2 srcSel data after two good windows", int'(srcSel), 1);
    check("R8 pulse on lock rise", int'(statusChg), 1);
    stepEdge();
    check("R8 pulse lasts one cycle", int'(statusChg), 0);
    #(REF_PERIOD * 0.1);
    check("R7 rxClkOut follows recClk a", int'(rxClkOut), int'(recClk));
    #(REF_PERIOD * 0.3);
    check("R7 rxClkOut follows recClk b", int'(rxClkOut), int'(recClk));
  endtask

  task automatic t_drift();
    waitEdge(3 * WIN + 2);
    recHalf = 5.01;      // 2000 ppm slow
    waitEdge(4 * WIN + 5);
    check("R3 single bad window keeps lock", int'(lockDet), 1);
    waitEdge(5 * WIN);
    check("R2 lock lost after two bad windows", int'(lockDet), 0);
    check("R2 srcSel back to reference", int'(srcSel), 0);
    recHalf = 5.001;     // 200 ppm slow, inside the band
    waitEdge(6 * WIN + 5);
    check("R3 one good window after drift", int'(lockDet), 0);
    check("R7 rxClkOut from refClk in fallback", int'(rxClkOut), int'(refClk));
    waitEdge(7 * WIN);
    check("R2 200 ppm accepted, lock regained", int'(lockDet), 1);
    recHalf = REF_PERIOD / 2.0;
  endtask

  task automatic t_los();
    waitEdge(7 * WIN + 100);
    losRaw = 1'b1;       // polarity 1: high flag means loss
    stepEdge();
    check("R5 losDet not yet after one edge", int'(losDet), 0);
    check("R6 data still passes", int'(rxDataOut), 10);
    stepEdge();
    check("R5 losDet after two edges", int'(losDet), 1);
    check("R6 data muted during LOS", int'(rxDataOut), 0);
    check("R8 pulse on LOS rise", int'(statusChg), 1);
    stepEdge();
    check("R4 LOS drops lock", int'(lockDet), 0);
    check("R8 pulse on lock fall", int'(statusChg), 1);
    stepEdge();
    check("R8 pulse ends", int'(statusChg), 0);
    muteEn = 1'b0;
    #1;
    check("R6 mute disabled passes data", int'(rxDataOut), 10);
    muteEn = 1'b1;
    waitEdge(8 * WIN + 10);
    check("R4 good window under LOS ignored", int'(lockDet), 0);
    waitEdge(9 * WIN + 10);
    check("R4 second good window under LOS ignored", int'(lockDet), 0);
    losRaw = 1'b0;
    stepEdge();
    stepEdge();
    check("R5 losDet clears", int'(losDet), 0);
    check("R6 data restored", int'(rxDataOut), 10);
    waitEdge(10 * WIN + 5);
    check("R3 one window after LOS keeps reference", int'(lockDet), 0);
    waitEdge(11 * WIN);
    check("R3 relock two windows after LOS", int'(lockDet), 1);
  endtask

  task automatic t_polarity();
    waitEdge(11 * WIN + 50);
    losPolarity = 1'b0;  // active-low module, flag low means loss
    #1;
    check("R5 polarity flip shows at once", int'(losDet), 1);
    stepEdge();
    check("R4 lock dropped on inverted LOS", int'(lockDet), 0);
    losRaw = 1'b1;
    stepEdge();
    stepEdge();
    check("R5 active-low flag high clears LOS", int'(losDet), 0);
  endtask

  initial begin
    repeat (5) @(negedge refClk);
    t_reset();
    t_acquire();
    t_drift();
    t_los();
    t_polarity();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge refClk);
    fails++;
    tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule